// File: doc/BRIEF.md
# Snapshot Byte Reader for a Position Counter

This block lets an 8-bit host bus read a position counter that is 12 or 16 bits wide and keeps running while the host reads it. An internal position register copies the counter on every clock edge. When the host starts a read of the upper byte, the register is frozen. Both bytes then come from one coherent value, however far the counter moves during the two accesses. When the host has read the lower byte and released the bus, the register follows the counter again.

The host uses an active-low read strobe and a byte-select line. With select low it reads the upper byte, and with select high the lower byte. The bus is presented as a data byte plus a drive-enable for the pad cell, which together form a tri-state port. A host that needs only eight bits keeps select high at all times. In that case the freeze is never armed and the lower byte tracks the counter directly.

Top module: `byte_read_if`

## Requirements
- R1: When the position register is not frozen, it takes the value of `cnt_i` at each rising clock edge.
- R2: `bus_en` is 1 exactly while `oe_n` is 0. While `bus_en` is 0, `bus_d` is 8'h00.
- R3: With `oe_n` low, `sel` = 0 puts the upper byte of the register (bits 15..8, zero-extended) on `bus_d`, and `sel` = 1 puts bits 7..0 on it.
- R4: A clock edge that sees `oe_n` = 0 and `sel` = 0 does not update the register. The freeze then holds, so both bytes show the value captured at the last edge before the read began.
- R5: The freeze is released by a clock edge that sees `oe_n` high after it was low, with `sel` = 1. That edge still leaves the register unchanged, and tracking resumes at the edge after it.
- R6: If the read strobe is released with `sel` = 0 after an upper-byte-only read, the freeze stays set until a lower-byte read is completed.
- R7: While `sel` stays 1, the register is never frozen and the lower byte follows the counter during a read.
- R8: With `CNT_W` = 12, bits 7..4 of the upper byte read as 0.
- R9: Synchronous active-high `rst` clears the register to 0 and clears the freeze.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Free-running counter value |
| oe_n | input | 1 | Active-low read strobe |
| sel | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| bus_en | output | 1 | Pad drive enable (1 = drive, 0 = high impedance) |
| bus_d | output | 8 | Byte driven onto the bus |

## Verification
The following rules are checked on every cycle by properties:
- the register copies the counter whenever it is not frozen, and stays stable whenever it is frozen;
- an upper-byte read arms the freeze;
- a completed lower-byte release clears the freeze, while a release with select low keeps it;
- the bus stays idle while the strobe is high.

Some behaviour only the bench scenarios can show. One case is that the bytes of one read agree with the counter value from before the strobe fell, while the counter runs with different strides and wraps. The others are the one-edge delay before tracking resumes, the free-running lower byte in 8-bit use, and the zeroed upper nibble of the 12-bit variant.

// File: rtl/byte_read_pkg.sv
package byte_read_pkg;

    localparam int BUS_W  = 8;
    localparam int WIDE_W = 16;

    typedef enum logic {
        BYTE_HI = 1'b0,
        BYTE_LO = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic             en;
        logic [BUS_W-1:0] d;
    } bus_drv_t;

    function automatic logic [BUS_W-1:0] pick_byte(
        input logic [WIDE_W-1:0] v,
        input byte_sel_e         s
    );
        return (s == BYTE_LO) ? v[BUS_W-1:0] : v[WIDE_W-1:BUS_W];
    endfunction

endpackage

// File: rtl/rd_inhibit.sv
module rd_inhibit
    import byte_read_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      oe_n,
    input  byte_sel_e sel,
    output logic      hold
);

    logic hold_q;
    logic oe_q;
    logic start_rd;
    logic done_rd;

    assign start_rd = !oe_n && (sel == BYTE_HI);
    assign done_rd  = oe_n && !oe_q && (sel == BYTE_LO);
    assign hold     = hold_q || start_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            oe_q   <= 1'b1;
        end else begin
            oe_q <= oe_n;
            if (start_rd) begin
                hold_q <= 1'b1;
            end else if (done_rd) begin
                hold_q <= 1'b0;
            end
        end
    end

    // R4
    hi_rd_arms_chk: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && sel == BYTE_HI) |=> hold_q);

    // R5
    lo_release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hold_q && oe_n && !$past(oe_n) && sel == BYTE_LO) |=> !hold_q);

    // R6
    hi_release_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && oe_n && sel == BYTE_HI) |=> hold_q);

endmodule

// File: rtl/pos_latch.sv
module pos_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] pos
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (!hold) begin
            pos <= cnt;
        end
    end

    // R1
    track_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (pos == $past(cnt)));

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(pos));

endmodule

// File: rtl/byte_mux.sv
module byte_mux
    import byte_read_pkg::*;
(
    input  logic              oe_n,
    input  byte_sel_e         sel,
    input  logic [WIDE_W-1:0] wide,
    output logic              bus_en,
    output logic [BUS_W-1:0]  bus_d
);

    bus_drv_t drv;

    always_comb begin
        drv.en = !oe_n;
        drv.d  = drv.en ? pick_byte(wide, sel) : '0;
    end

    assign bus_en = drv.en;
    assign bus_d  = drv.d;

endmodule

// File: rtl/byte_read_if.sv
module byte_read_if
    import byte_read_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             oe_n,
    input  logic             sel,
    output logic             bus_en,
    output logic [BUS_W-1:0] bus_d
);

    localparam int PAD_W = WIDE_W - CNT_W;

    byte_sel_e         sel_e;
    logic              hold;
    logic [CNT_W-1:0]  pos;
    logic [WIDE_W-1:0] wide;

    assign sel_e = byte_sel_e'(sel);

    rd_inhibit u_inhibit (
        .clk  (clk),
        .rst  (rst),
        .oe_n (oe_n),
        .sel  (sel_e),
        .hold (hold)
    );

    pos_latch #(.W(CNT_W)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .cnt  (cnt_i),
        .pos  (pos)
    );

    generate
        if (PAD_W == 0) begin : g_full
            assign wide = pos;
        end else begin : g_pad
            assign wide = {{PAD_W{1'b0}}, pos};
        end
    endgenerate

    byte_mux u_mux (
        .oe_n   (oe_n),
        .sel    (sel_e),
        .wide   (wide),
        .bus_en (bus_en),
        .bus_d  (bus_d)
    );

    // R2
    bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!bus_en && bus_d == '0));

endmodule

// File: tb/tb_byte_read_if.sv
module tb_byte_read_if;

    logic        clk = 1'b0;
    logic        rst;
    logic        oe_n;
    logic        sel;
    logic [15:0] cnt;
    logic        en16, en12;
    logic [7:0]  d16, d12;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    // {start, step, expected upper byte, expected lower byte}
    localparam logic [39:0] VEC [4] = '{
        40'h1234_01_12_34,
        40'h00FF_03_00_FF,
        40'hFFFF_01_FF_FF,
        40'h8001_80_80_01
    };

    byte_read_if #(.CNT_W(16)) dut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .oe_n(oe_n), .sel(sel),
        .bus_en(en16), .bus_d(d16)
    );

    byte_read_if #(.CNT_W(12)) dut12 (
        .clk(clk), .rst(rst), .cnt_i(cnt[11:0]), .oe_n(oe_n), .sel(sel),
        .bus_en(en12), .bus_d(d12)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] last;
        logic [15:0] snap;
        rst = 1'b1; oe_n = 1'b1; sel = 1'b1; cnt = 16'h5A5A;
        repeat (3) @(negedge clk);
        #1 chk("R9 bus idle in reset", {7'b0, en16}, 8'h00);
        @(negedge clk); oe_n = 1'b0; sel = 1'b1;
        #1 chk("R9 register cleared", d16, 8'h00);
        chk("R2 enable follows strobe", {7'b0, en16}, 8'h01);
        @(negedge clk); oe_n = 1'b1; rst = 1'b0;

        for (int i = 0; i < 4; i++) begin
            logic [15:0] st;
            logic [7:0]  stp, eh, el;
            st = VEC[i][39:24]; stp = VEC[i][23:16];
            eh = VEC[i][15:8];  el = VEC[i][7:0];
            @(negedge clk); cnt = st; oe_n = 1'b1; sel = 1'b1;
            @(negedge clk); cnt = cnt + 16'(stp); oe_n = 1'b0; sel = 1'b0;
            #1 chk("R3 upper byte", d16, eh);
            chk("R8 12-bit upper nibble zero", d12, {4'h0, st[11:8]});
            repeat (3) begin
                @(negedge clk); cnt = cnt + 16'(stp);
                #1 chk("R4 upper byte frozen", d16, eh);
            end
            @(negedge clk); cnt = cnt + 16'(stp); sel = 1'b1;
            #1 chk("R4 lower byte same snapshot", d16, el);
            chk("R3 lower byte 12-bit", d12, st[7:0]);
            @(negedge clk); cnt = cnt + 16'(stp); oe_n = 1'b1;
            #1 chk("R2 enable low", {7'b0, en16}, 8'h00);
            chk("R2 data zero when idle", d16, 8'h00);
        end

        // R5: the release edge keeps the value, then tracking resumes
        @(negedge clk); cnt = cnt + 16'h0011; oe_n = 1'b0; sel = 1'b1;
        #1 chk("R5 release edge keeps value", d16, 8'h01);
        // R7: select held high, no freeze, the lower byte tracks
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); last = cnt; cnt = cnt + 16'h0011;
            #1 chk("R7 lower byte tracks counter", d16, last[7:0]);
        end
        @(negedge clk); oe_n = 1'b1;

        // R6: upper-only read released with select low keeps the freeze
        @(negedge clk); snap = cnt; cnt = cnt + 16'd3; oe_n = 1'b0; sel = 1'b0;
        #1 chk("R6 upper byte", d16, snap[15:8]);
        @(negedge clk); cnt = cnt + 16'd3; oe_n = 1'b1;
        repeat (4) begin @(negedge clk); cnt = cnt + 16'd3; end
        @(negedge clk); cnt = cnt + 16'd3; oe_n = 1'b0; sel = 1'b1;
        #1 chk("R6 lower byte still snapshot", d16, snap[7:0]);
        chk("R6 lower byte still snapshot 12-bit", d12, snap[7:0]);
        @(negedge clk); sel = 1'b0;
        #1 chk("R6 upper byte still snapshot", d16, snap[15:8]);
        @(negedge clk); sel = 1'b1;
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk); last = cnt; cnt = cnt + 16'd3; oe_n = 1'b0; sel = 1'b1;
        #1 chk("R5 tracking resumed after release", d16, last[7:0]);
        @(negedge clk); last = cnt; cnt = cnt + 16'd3;
        #1 chk("R1 register follows counter", d16, last[7:0]);

        // R9: reset during a frozen read clears the freeze
        @(negedge clk); oe_n = 1'b0; sel = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; oe_n = 1'b1; sel = 1'b1;
        @(negedge clk); last = cnt; cnt = cnt + 16'd5; oe_n = 1'b0;
        #1 chk("R9 freeze cleared by reset", d16, last[7:0]);
        @(negedge clk); oe_n = 1'b1;
        #1 chk("R2 idle after read", d16, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule